// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns level changes on a vector of GPIO pad values into latched interrupt requests. Each pad value first passes through a flop synchroniser. The synchronised value is then compared with its own value one clock earlier to find rising and falling edges. Each pin has two edge enables, one for rising edges and one for falling edges. Software changes them only through write-one-to-set and write-one-to-clear locations, so no read-modify-write is needed. An enabled edge sets a sticky status bit. Software clears that bit by writing a 1 to it.

The status bits are grouped into 16-pin banks. Each bank drives one level interrupt line, and a global bank-enable register gates those lines. The lowest pins also drive a direct one-cycle interrupt pulse each, for a consumer that wants one line per pin. The pad value is taken regardless of pad direction, so a pin that is driven as an output can also trigger its own interrupt.

Software reaches the registers through a single-cycle write strobe and a combinational read port that share one byte address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every edge enable, every status bit and every bank enable is 0, every bank line and direct pulse is low, and every register reads 0.
- R2: Each 32-pin register set k starts at byte address 0x10 + 0x20*k. A write at +0x04 sets the rising enables where the data bits are 1, and a write at +0x08 clears them there. Writes at +0x0C and +0x10 do the same for the falling enables. Data bits that are 0 change nothing. Reads at +0x04 and +0x08 return the rising enables, and reads at +0x0C and +0x10 return the falling enables.
- R3: Each pad value passes two synchroniser flops. An edge is the synchronised value differing from its value one clock earlier. A pad change made between clock edges sets the pin's status bit on the third rising clock edge after the change, if that edge direction is enabled. An edge whose direction is disabled leaves the status bit unchanged.
- R4: A pin with both enables set latches status on a rising edge and also on a falling edge.
- R5: Status is read at +0x00 of its register set. Writing 1 there clears that bit. Writing 0 leaves the bit as it was.
- R6: If an enabled edge is detected in the same cycle as a write-one-to-clear of that bit, the bit ends the cycle set.
- R7: Bank k covers status bits of register set k/2: the lower 16 bits when k is even and the upper 16 when k is odd. Bank line k is high exactly while bank-enable bit k is 1 and any status bit of its 16 pins is set. It is a level, not a pulse.
- R8: The bank-enable register sits at byte address 0x08, with bit k controlling bank k. It is written directly and reads back what was written.
- R9: For each pin below NDIRECT, a direct output pulses high for exactly one cycle. The pulse lands in the same cycle that an enabled edge on that pin reaches the status register, whether or not the status bit was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw pad values, asynchronous to clk |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | ADDR_W | Byte address shared by write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data at addr |
| bank_irq | output | NPINS/16 | Per-bank level interrupt lines |
| pin_irq | output | NDIRECT | Direct per-pin interrupt pulses |

## Verification
The hardest situation to reach from the ports is a new edge that lands on the same clock as a write-one-to-clear of the same status bit. The edge takes three clocks to cross the synchroniser and the compare stage. The directed test therefore changes the pad and waits exactly two cycles before issuing the clear, so the detected edge and the clear meet at one clock edge. Random pad toggling mixed with random register writes then reaches the same collision and the enable set/clear races in many other combinations. A bench model tracks all of them cycle by cycle.

// File: rtl/gei_pkg.sv
`timescale 1ns/1ps
package gei_pkg;
  localparam int unsigned REG_W          = 32;
  localparam int unsigned BANK_PINS      = 16;
  localparam int unsigned GLOBAL_EN_ADDR = 32'h08;
  localparam int unsigned SET_BASE       = 32'h10;
  localparam int unsigned SET_STRIDE     = 32'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_RISE_SET,
    SEL_RISE_CLR,
    SEL_FALL_SET,
    SEL_FALL_CLR
  } reg_sel_e;

  function automatic logic [31:0] set_base(input int unsigned k);
    return 32'(SET_BASE + SET_STRIDE * k);
  endfunction

  // Map a byte address onto a register of register set k.
  function automatic reg_sel_e decode_sel(input logic [31:0] a, input int unsigned k);
    logic [31:0] d;
    d = a - set_base(k);
    if (a < set_base(k)) return SEL_NONE;
    case (d)
      32'h00:  return SEL_STATUS;
      32'h04:  return SEL_RISE_SET;
      32'h08:  return SEL_RISE_CLR;
      32'h0C:  return SEL_FALL_SET;
      32'h10:  return SEL_FALL_CLR;
      default: return SEL_NONE;
    endcase
  endfunction

  // Bank k lives in register set k/2; odd banks take the upper half.
  function automatic int unsigned bank_set(input int unsigned k);
    return k / 2;
  endfunction

  function automatic int unsigned bank_lsb(input int unsigned k);
    return (k % 2) * BANK_PINS;
  endfunction
endpackage

// File: rtl/gei_sync_edge.sv
`timescale 1ns/1ps
module gei_sync_edge #(
  parameter int unsigned N      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_raw,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  // chain[STAGES-1] is the synchronised value.
  logic [STAGES-1:0][N-1:0] chain;
  logic [N-1:0]             prev_q;
  logic [N-1:0]             sync_v;

  assign sync_v = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= '0;
    end else begin
      chain  <= {chain[STAGES-2:0], pin_raw};
      prev_q <= sync_v;
    end
  end

  assign rise_o = sync_v & ~prev_q;
  assign fall_o = ~sync_v & prev_q;

  // The compare stage must see each synchronised step exactly once.
  p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/gei_regset.sv
`timescale 1ns/1ps
module gei_regset import gei_pkg::*; #(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] rise_evt,
  input  logic [W-1:0] fall_evt,
  output logic [W-1:0] status,
  output logic [W-1:0] hit,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] rise_en, fall_en;
  logic [W-1:0] clr_mask;
  logic         rs_stb, rc_stb, fs_stb, fc_stb;

  assign rs_stb   = wr_en && (sel == SEL_RISE_SET);
  assign rc_stb   = wr_en && (sel == SEL_RISE_CLR);
  assign fs_stb   = wr_en && (sel == SEL_FALL_SET);
  assign fc_stb   = wr_en && (sel == SEL_FALL_CLR);
  assign clr_mask = (wr_en && (sel == SEL_STATUS)) ? wr_data : '0;

  assign hit = (rise_evt & rise_en) | (fall_evt & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      if (rs_stb)      rise_en <= rise_en | wr_data;
      else if (rc_stb) rise_en <= rise_en & ~wr_data;
      if (fs_stb)      fall_en <= fall_en | wr_data;
      else if (fc_stb) fall_en <= fall_en & ~wr_data;
      // A new event wins over a clear of the same bit.
      status <= (status & ~clr_mask) | hit;
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS:                 rd_val = status;
      SEL_RISE_SET, SEL_RISE_CLR: rd_val = rise_en;
      SEL_FALL_SET, SEL_FALL_CLR: rd_val = fall_en;
      default:                    rd_val = '0;
    endcase
  end

  p_rise_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_stb |=> ((rise_en & $past(wr_data)) == $past(wr_data)));
  p_rise_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rc_stb |=> ((rise_en & $past(wr_data)) == '0));
  p_fall_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_stb |=> ((fall_en & $past(wr_data)) == $past(wr_data)));
  p_fall_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fc_stb |=> ((fall_en & $past(wr_data)) == '0));
  p_status_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));
  p_only_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));
endmodule

// File: rtl/gei_bank_gate.sv
`timescale 1ns/1ps
module gei_bank_gate import gei_pkg::*; #(
  parameter int unsigned NPINS  = 64,
  parameter int unsigned NBANKS = NPINS / BANK_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  status_all,
  input  logic [NBANKS-1:0] bank_en,
  output logic [NBANKS-1:0] bank_irq
);
  logic [NBANKS-1:0] pend;

  for (genvar k = 0; k < NBANKS; k++) begin : g_bank
    localparam int unsigned LO = bank_set(k) * REG_W + bank_lsb(k);
    assign pend[k]     = |status_all[LO +: BANK_PINS];
    assign bank_irq[k] = pend[k] & bank_en[k];

    p_bank_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_irq[k] && $past(bank_irq[k])) |-> $past(bank_en[k]));
  end
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq import gei_pkg::*; #(
  parameter int unsigned NPINS       = 64,
  parameter int unsigned NDIRECT     = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPINS-1:0]              pin_in,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wr_data,
  output logic [31:0]                   rd_data,
  output logic [NPINS/BANK_PINS-1:0]    bank_irq,
  output logic [NDIRECT-1:0]            pin_irq
);
  localparam int unsigned NSETS  = NPINS / REG_W;
  localparam int unsigned NBANKS = NPINS / BANK_PINS;

  logic [NPINS-1:0]  rise_all, fall_all, status_all, hit_all;
  logic [31:0]       rd_part [NSETS];
  logic [NBANKS-1:0] bank_en;
  logic [NDIRECT-1:0] pin_irq_q;
  logic              ben_sel;

  gei_sync_edge #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
    .rise_o(rise_all), .fall_o(fall_all)
  );

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    reg_sel_e sel_k;
    assign sel_k = decode_sel(32'(addr), k);
    gei_regset #(.W(REG_W)) u_set (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel_k), .wr_data(wr_data),
      .rise_evt(rise_all[k*REG_W +: REG_W]), .fall_evt(fall_all[k*REG_W +: REG_W]),
      .status(status_all[k*REG_W +: REG_W]), .hit(hit_all[k*REG_W +: REG_W]),
      .rd_val(rd_part[k])
    );
  end

  assign ben_sel = (32'(addr) == GLOBAL_EN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en   <= '0;
      pin_irq_q <= '0;
    end else begin
      if (wr_en && ben_sel) bank_en <= wr_data[NBANKS-1:0];
      pin_irq_q <= hit_all[NDIRECT-1:0];
    end
  end

  always_comb begin
    rd_data = ben_sel ? 32'(bank_en) : 32'h0;
    for (int k = 0; k < NSETS; k++) rd_data = rd_data | rd_part[k];
  end

  assign pin_irq = pin_irq_q;

  gei_bank_gate #(.NPINS(NPINS), .NBANKS(NBANKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .status_all(status_all),
    .bank_en(bank_en), .bank_irq(bank_irq)
  );

  p_hit_latches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_all) |=> ((status_all & $past(hit_all)) == $past(hit_all)));
  p_ben_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ben_sel) |=> (bank_en == $past(wr_data[NBANKS-1:0])));

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank_chk
    p_bank_drop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_irq[b]) |-> $past(wr_en));
  end

  for (genvar i = 0; i < NDIRECT; i++) begin : g_pin_chk
    p_pin_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_irq[i] |-> status_all[i]);
  end
endmodule

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  localparam int NP = 64, ND = 16, NB = 4, NS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0] pin;
  logic          we;
  logic [7:0]    addr;
  logic [31:0]   wd;
  wire  [31:0]   rd_data;
  wire  [NB-1:0] bank_irq;
  wire  [ND-1:0] pin_irq;

  gpio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .wr_en(we), .addr(addr),
    .wr_data(wd), .rd_data(rd_data), .bank_irq(bank_irq), .pin_irq(pin_irq)
  );

  logic [NP-1:0] m_rise, m_fall, m_stat, s1, s2, prv;
  logic [NB-1:0] m_ben;
  logic [ND-1:0] m_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h08) return {28'h0, m_ben};
    for (int k = 0; k < NS; k++) begin
      logic [7:0] b;
      b = 8'(16 + 32 * k);
      if (a == b)        return m_stat[32*k +: 32];
      if (a == b + 8'h4) return m_rise[32*k +: 32];
      if (a == b + 8'h8) return m_rise[32*k +: 32];
      if (a == b + 8'hC) return m_fall[32*k +: 32];
      if (a == b + 8'h10) return m_fall[32*k +: 32];
    end
    return 32'h0;
  endfunction

  function automatic logic [NB-1:0] m_bank();
    logic [NB-1:0] r;
    for (int k = 0; k < NB; k++) r[k] = m_ben[k] & (|m_stat[16*k +: 16]);
    return r;
  endfunction

  task automatic model_step();
    logic [NP-1:0] h, clr;
    h = (s2 & ~prv & m_rise) | (~s2 & prv & m_fall);
    clr = '0;
    if (we) begin
      for (int k = 0; k < NS; k++) begin
        logic [7:0] b;
        b = 8'(16 + 32 * k);
        if (addr == b)         clr[32*k +: 32] = wd;
        if (addr == b + 8'h4)  m_rise[32*k +: 32] = m_rise[32*k +: 32] | wd;
        if (addr == b + 8'h8)  m_rise[32*k +: 32] = m_rise[32*k +: 32] & ~wd;
        if (addr == b + 8'hC)  m_fall[32*k +: 32] = m_fall[32*k +: 32] | wd;
        if (addr == b + 8'h10) m_fall[32*k +: 32] = m_fall[32*k +: 32] & ~wd;
      end
      if (addr == 8'h08) m_ben = wd[NB-1:0];
    end
    m_stat  = (m_stat & ~clr) | h;
    m_pulse = h[ND-1:0];
    prv = s2; s2 = s1; s1 = pin;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, rd_data, m_read(addr));
    chk("R7", bank_irq, m_bank());
    chk("R9", pin_irq, m_pulse);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    we = 1'b1; addr = a; wd = d;
    cyc(tag);
    we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 12)
      0: return 8'h08;  1: return 8'h10;  2: return 8'h14;  3: return 8'h18;
      4: return 8'h1C;  5: return 8'h20;  6: return 8'h30;  7: return 8'h34;
      8: return 8'h38;  9: return 8'h3C; 10: return 8'h40;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    pin = '0; we = 1'b0; addr = '0; wd = '0;
    m_rise = '0; m_fall = '0; m_stat = '0; s1 = '0; s2 = '0; prv = '0;
    m_ben = '0; m_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything quiet after reset
    foreach (m_stat[i]) if (i < 11) begin
      peek(8'(i == 0 ? 8'h08 : (i < 6 ? 8'h10 + 8'(4*(i-1)) : 8'h30 + 8'(4*(i-6)))), v);
      chk("R1", v, 0);
    end
    chk("R1", bank_irq, 0);
    chk("R1", pin_irq, 0);
    idle(2, "R1");

    // R2: set/clear enables, readback on both aliases
    wr(8'h14, 32'h0000_00FF, "R2");
    peek(8'h14, v); chk("R2", v, 32'hFF);
    wr(8'h18, 32'h0000_000F, "R2");
    peek(8'h18, v); chk("R2", v, 32'hF0);
    wr(8'h14, 32'h0, "R2");
    peek(8'h14, v); chk("R2", v, 32'hF0);

    // R8: bank enable register
    wr(8'h08, 32'hF, "R8");
    peek(8'h08, v); chk("R8", v, 32'hF);

    // R3: exact latency, disabled pin ignored
    pin[4] = 1'b1; pin[0] = 1'b1;
    idle(2, "R3");
    peek(8'h10, v); chk("R3", v, 32'h0);
    cyc("R3");
    peek(8'h10, v); chk("R3", v, 32'h10);

    // R4: both edges on pin 40 (set 1, bit 8)
    wr(8'h34, 32'h100, "R4");
    wr(8'h3C, 32'h100, "R4");
    pin[40] = 1'b1;
    idle(3, "R4");
    peek(8'h30, v); chk("R4", v, 32'h100);
    wr(8'h30, 32'h100, "R4");
    peek(8'h30, v); chk("R4", v, 32'h0);
    pin[40] = 1'b0;
    idle(3, "R4");
    peek(8'h30, v); chk("R4", v, 32'h100);

    // R7: bank gating and odd-bank upper-half mapping
    chk("R7", bank_irq, 4'b0101);
    wr(8'h08, 32'h1, "R7");
    chk("R7", bank_irq, 4'b0001);
    wr(8'h08, 32'hF, "R7");
    wr(8'h14, 32'h0010_0000, "R7");
    pin[20] = 1'b1;
    idle(3, "R7");
    chk("R7", bank_irq, 4'b0111);

    // R5: zero write keeps, one write clears
    wr(8'h10, 32'h0, "R5");
    peek(8'h10, v); chk("R5", v, 32'h0010_0010);
    wr(8'h10, 32'h10, "R5");
    peek(8'h10, v); chk("R5", v, 32'h0010_0000);

    // R6 + R9: edge meets clear on the same clock
    pin[4] = 1'b0;
    idle(3, "R6");
    pin[4] = 1'b1;
    idle(2, "R6");
    wr(8'h10, 32'h10, "R6");
    chk("R9", pin_irq[4], 1);
    peek(8'h10, v); chk("R6", v[4], 1);
    cyc("R9");
    chk("R9", pin_irq[4], 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      pin = pin ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      we = (($urandom % 3) == 0);
      addr = pick_addr();
      wd = $urandom;
      cyc("R3");
    end
    we = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule